// File: doc/BRIEF.md
# Threshold-Controlled Justification Elastic Store

This block is the elastic buffer of one tributary channel. Tributary data arrives one word at a time on a write strobe. It may come from a DS1/E1-rate line or from a looped-back virtual-tributary payload. The data is drained on a read strobe that the local SONET/SDH frame timing paces. Both sides share one clock and are qualified by enables. The block keeps a count of the unused locations in its 128-entry ring.

At each justification-opportunity strobe, the block compares that count against two programmable 7-bit thresholds and issues a stuffing decision to the downstream mapper. When unused space is above the high threshold, it asks for a positive stuff and one data unit is withheld. When unused space is below the low threshold, it asks for a negative stuff and one extra unit is carried. Otherwise no justification is made. Justification is only active in asynchronous mode. The two synchronous modes force the decision to no-stuff.

A write into a full buffer is counted as overflow. Overflow raises a sticky event bit, and that bit drives a maskable interrupt. Switching to the loopback source, or changing the mode, discards the buffer contents and recentres the buffer at half full.

Top module: `jes_elastic_store`

## Requirements
- R1: After reset, unused_o = 128, just_o = 00, rd_data_o = 0, evt_o = 0 and irq_o = 0. The thresholds hold high = 0x28 (40) and low = 0x27 (39).
- R2: Accepted words are read out in the order they were written. rd_data_o shows a word in the cycle after its read strobe. Each accepted write lowers unused_o by one and each accepted read raises it by one.
- R3: A write while unused_o = 0 is dropped: unused_o stays 0, the word never appears at the read side, and evt_o becomes 1.
- R4: A read while unused_o = 128 loads 0 into rd_data_o and leaves unused_o unchanged.
- R5: In mode 00 (asynchronous), an opportunity strobe with unused_o above the high threshold sets just_o = 01 (positive stuff).
- R6: In mode 00, an opportunity strobe with unused_o below the low threshold sets just_o = 10 (negative stuff).
- R7: In mode 00, an opportunity strobe with unused_o between the thresholds (inclusive) sets just_o = 00. just_o never shows 11, and it changes only at an opportunity strobe or a recentre.
- R8: In modes 01 (bit-synchronous), 10 (byte-synchronous) and the spare code 11, just_o stays 00 whatever the occupancy.
- R9: A one-cycle thr_ld_i pulse loads thr_hi_i and thr_lo_i. With the loopback values high = 5 and low = 4, unused 6 gives 01, unused 5 and 4 give 00, and unused 3 gives 10.
- R10: evt_o stays set until a one-cycle evt_clr_i pulse clears it. If an overflow happens in the same cycle as the clear, evt_o stays 1.
- R11: irq_o is 1 exactly while evt_o = 1 and int_mask_i = 0.
- R12: A rising edge of loop_sel_i, or a change of mode_i, sets unused_o to 64 and just_o to 00 in the next cycle. The write and read of that cycle are discarded. Holding loop_sel_i high causes no further recentre.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock shared by both sides |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_i | input | 2 | 00 async, 01 bit-sync, 10 byte-sync, 11 spare (no justification) |
| loop_sel_i | input | 1 | 1 selects the looped-back payload source |
| wr_en_i | input | 1 | Write strobe |
| wr_data_i | input | 8 | Write word |
| rd_en_i | input | 1 | Read strobe |
| rd_data_o | output | 8 | Read word, registered |
| unused_o | output | 8 | Number of unused locations (0..128) |
| opp_i | input | 1 | Justification-opportunity strobe |
| thr_ld_i | input | 1 | Load pulse for both thresholds |
| thr_hi_i | input | 7 | High threshold value (positive stuff) |
| thr_lo_i | input | 7 | Low threshold value (negative stuff) |
| just_o | output | 2 | Held decision: 00 none, 01 positive, 10 negative |
| evt_clr_i | input | 1 | Clear pulse for the overflow event |
| int_mask_i | input | 1 | Interrupt mask |
| evt_o | output | 1 | Sticky overflow event |
| irq_o | output | 1 | Interrupt request |

## Verification
Two functions can act on the same cycle: a fresh overflow, and the software pulse that clears the sticky event. The bench fills the ring to zero unused locations. It then drives a write and evt_clr_i on the same edge and expects evt_o to read 1 afterwards. A lone clear, by contrast, must read 0. The scoreboard also drains the full ring to confirm that the dropped word never surfaced.

// File: rtl/jes_pkg.sv
// Shared types of the elastic store: operating modes and stuffing decisions.
// Assumes nothing beyond a 2-bit mode code and a 2-bit decision code.
package jes_pkg;

    typedef enum logic [1:0] {
        MODE_ASYNC    = 2'b00,
        MODE_BITSYNC  = 2'b01,
        MODE_BYTESYNC = 2'b10,
        MODE_SPARE    = 2'b11
    } jes_mode_e;

    typedef enum logic [1:0] {
        JUST_NONE = 2'b00,
        JUST_POS  = 2'b01,
        JUST_NEG  = 2'b10
    } jes_just_e;

endpackage

// File: rtl/jes_ring.sv
// Ring buffer with a fill counter and a recentre (flush) input.
// Assumes DEPTH is a power of two. A write when full and a read when empty
// are refused. An empty read returns zero. Flush takes priority over both
// strobes and places the read pointer half a ring behind the write pointer.
module jes_ring #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = AW + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CW-1:0]     unused_o,
    output logic              ovf_o
);
    localparam int HALF = DEPTH / 2;

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr_q, rptr_q;
    logic [CW-1:0]     fill_q;
    logic              full_w, empty_w, wr_ok_w, rd_ok_w;

    // Qualify the strobes against occupancy and flush.
    always_comb begin
        full_w  = (fill_q == CW'(DEPTH));
        empty_w = (fill_q == '0);
        wr_ok_w = wr_en_i && !full_w && !flush_i;
        rd_ok_w = rd_en_i && !empty_w && !flush_i;
        ovf_o   = wr_en_i && full_w && !flush_i;
    end

    // Storage array write; contents are not reset.
    always_ff @(posedge clk) begin
        if (wr_ok_w) mem[wptr_q] <= wr_data_i;
    end

    // Pointer and fill bookkeeping, including recentre.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q <= '0;
            rptr_q <= '0;
            fill_q <= '0;
        end else if (flush_i) begin
            wptr_q <= rptr_q + AW'(HALF);
            fill_q <= CW'(HALF);
        end else begin
            if (wr_ok_w) wptr_q <= wptr_q + 1'b1;
            if (rd_ok_w) rptr_q <= rptr_q + 1'b1;
            fill_q <= fill_q + CW'(wr_ok_w) - CW'(rd_ok_w);
        end
    end

    // Registered read port; an empty read yields zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data_o <= '0;
        end else if (rd_en_i && !flush_i) begin
            rd_data_o <= empty_w ? '0 : mem[rptr_q];
        end
    end

    assign unused_o = CW'(DEPTH) - fill_q;

endmodule

// File: rtl/jes_just_dec.sv
// Threshold registers and the per-opportunity stuffing decision.
// Assumes the occupancy count is at least as wide as the thresholds. The
// decision is registered at each opportunity strobe and held until the next
// one. It is forced to none outside asynchronous mode and on recentre.
module jes_just_dec
    import jes_pkg::*;
#(
    parameter int              THR_W  = 7,
    parameter int              CW     = 8,
    parameter logic [THR_W-1:0] HI_RST = 7'h28,
    parameter logic [THR_W-1:0] LO_RST = 7'h27
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             flush_i,
    input  logic             async_i,
    input  logic             opp_i,
    input  logic [CW-1:0]    unused_i,
    input  logic             thr_ld_i,
    input  logic [THR_W-1:0] thr_hi_i,
    input  logic [THR_W-1:0] thr_lo_i,
    output jes_just_e        just_o
);
    logic [THR_W-1:0] hi_q, lo_q;
    jes_just_e        cand_w;

    // Threshold registers, loaded together by a pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hi_q <= HI_RST;
            lo_q <= LO_RST;
        end else if (thr_ld_i) begin
            hi_q <= thr_hi_i;
            lo_q <= thr_lo_i;
        end
    end

    // Candidate decision from the current occupancy; positive has priority.
    always_comb begin
        cand_w = JUST_NONE;
        if (async_i) begin
            if (unused_i > CW'(hi_q))      cand_w = JUST_POS;
            else if (unused_i < CW'(lo_q)) cand_w = JUST_NEG;
        end
    end

    // Hold register for the decision.
    always_ff @(posedge clk) begin
        if (!rst_n)       just_o <= JUST_NONE;
        else if (flush_i) just_o <= JUST_NONE;
        else if (opp_i)   just_o <= cand_w;
    end

endmodule

// File: rtl/jes_ovf_evt.sv
// Sticky overflow event with clear pulse and interrupt mask.
// Assumes a new overflow wins over a clear in the same cycle.
module jes_ovf_evt (
    input  logic clk,
    input  logic rst_n,
    input  logic ovf_i,
    input  logic clr_i,
    input  logic mask_i,
    output logic evt_o,
    output logic irq_o
);
    // Sticky event register.
    always_ff @(posedge clk) begin
        if (!rst_n) evt_o <= 1'b0;
        else        evt_o <= ovf_i || (evt_o && !clr_i);
    end

    // Masked interrupt request.
    assign irq_o = evt_o && !mask_i;

endmodule

// File: rtl/jes_elastic_store.sv
// Top of the per-channel justification elastic store. Detects the recentre
// events (loopback select rising, any mode change) and wires the ring, the
// decision logic and the overflow event together. Assumes one clock domain.
module jes_elastic_store
    import jes_pkg::*;
#(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    parameter int THR_W  = 7,
    localparam int CW    = $clog2(DEPTH) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode_i,
    input  logic              loop_sel_i,
    input  logic              wr_en_i,
    input  logic [DATA_W-1:0] wr_data_i,
    input  logic              rd_en_i,
    output logic [DATA_W-1:0] rd_data_o,
    output logic [CW-1:0]     unused_o,
    input  logic              opp_i,
    input  logic              thr_ld_i,
    input  logic [THR_W-1:0]  thr_hi_i,
    input  logic [THR_W-1:0]  thr_lo_i,
    output logic [1:0]        just_o,
    input  logic              evt_clr_i,
    input  logic              int_mask_i,
    output logic              evt_o,
    output logic              irq_o
);
    logic [1:0] mode_q;
    logic       loop_q;
    logic       flush_w;
    logic       ovf_w;
    jes_just_e  just_w;

    // Previous mode and loopback select, for change detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= MODE_ASYNC;
            loop_q <= 1'b0;
        end else begin
            mode_q <= mode_i;
            loop_q <= loop_sel_i;
        end
    end

    // Recentre request.
    assign flush_w = (mode_i != mode_q) || (loop_sel_i && !loop_q);

    jes_ring #(.DATA_W(DATA_W), .DEPTH(DEPTH)) i_ring (
        .clk       (clk),
        .rst_n     (rst_n),
        .flush_i   (flush_w),
        .wr_en_i   (wr_en_i),
        .wr_data_i (wr_data_i),
        .rd_en_i   (rd_en_i),
        .rd_data_o (rd_data_o),
        .unused_o  (unused_o),
        .ovf_o     (ovf_w)
    );

    jes_just_dec #(.THR_W(THR_W), .CW(CW)) i_dec (
        .clk      (clk),
        .rst_n    (rst_n),
        .flush_i  (flush_w),
        .async_i  (mode_i == MODE_ASYNC),
        .opp_i    (opp_i),
        .unused_i (unused_o),
        .thr_ld_i (thr_ld_i),
        .thr_hi_i (thr_hi_i),
        .thr_lo_i (thr_lo_i),
        .just_o   (just_w)
    );

    assign just_o = just_w;

    jes_ovf_evt i_evt (
        .clk    (clk),
        .rst_n  (rst_n),
        .ovf_i  (ovf_w),
        .clr_i  (evt_clr_i),
        .mask_i (int_mask_i),
        .evt_o  (evt_o),
        .irq_o  (irq_o)
    );

endmodule

// File: rtl/jes_elastic_store_chk.sv
// Assertion checker for jes_elastic_store, attached by bind below.
// Assumes the recentre request of the top is brought in as flush.
module jes_elastic_store_chk #(
    parameter int DATA_W = 8,
    parameter int DEPTH  = 128,
    parameter int CW     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        mode_i,
    input logic              wr_en_i,
    input logic              rd_en_i,
    input logic [DATA_W-1:0] rd_data_o,
    input logic [CW-1:0]     unused_o,
    input logic              opp_i,
    input logic [1:0]        just_o,
    input logic              evt_clr_i,
    input logic              int_mask_i,
    input logic              evt_o,
    input logic              irq_o,
    input logic              flush
);
    // Unused count never exceeds the ring size (R2).
    assert_unused_bound_R2: assert property (@(posedge clk) disable iff (!rst_n)
        unused_o <= CW'(DEPTH));

    // Write into a full ring raises the event (R3).
    assert_full_write_evt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && unused_o == '0 && !flush) |=> evt_o);

    // Read of an empty ring gives zero and keeps it empty (R4).
    assert_empty_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en_i && !wr_en_i && unused_o == CW'(DEPTH) && !flush)
        |=> (rd_data_o == '0 && unused_o == CW'(DEPTH)));

    // Decision code is legal and moves only at opportunity or recentre (R7).
    assert_just_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        just_o != 2'b11);
    assert_just_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!opp_i && !flush) |=> $stable(just_o));

    // Synchronous modes never justify (R8).
    assert_sync_nostuff_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_i != 2'b00) |=> just_o == 2'b00);

    // Event holds until cleared (R10).
    assert_evt_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_o && !evt_clr_i) |=> evt_o);

    // Mask blocks the interrupt (R11).
    assert_mask_blocks_R11: assert property (@(posedge clk) disable iff (!rst_n)
        int_mask_i |-> !irq_o);

    // Recentre lands at half full (R12).
    assert_recentre_half_R12: assert property (@(posedge clk) disable iff (!rst_n)
        flush |=> unused_o == CW'(DEPTH / 2));

endmodule

bind jes_elastic_store jes_elastic_store_chk #(
    .DATA_W(DATA_W), .DEPTH(DEPTH), .CW(CW)
) i_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_i     (mode_i),
    .wr_en_i    (wr_en_i),
    .rd_en_i    (rd_en_i),
    .rd_data_o  (rd_data_o),
    .unused_o   (unused_o),
    .opp_i      (opp_i),
    .just_o     (just_o),
    .evt_clr_i  (evt_clr_i),
    .int_mask_i (int_mask_i),
    .evt_o      (evt_o),
    .irq_o      (irq_o),
    .flush      (flush_w)
);

// File: tb/test_jes_elastic_store.sv
// Scoreboard bench: write tasks push expected words, a monitor pops and
// compares them against the read port. All driving and sampling on negedge.
module test_jes_elastic_store;
    localparam int CLK_P = 10;
    localparam int DEPTH = 128;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] mode = 2'b00;
    logic       loop_sel = 1'b0, wr_en = 1'b0, rd_en = 1'b0, opp = 1'b0;
    logic [7:0] wr_data = '0;
    logic       thr_ld = 1'b0;
    logic [6:0] thr_hi = '0, thr_lo = '0;
    logic       evt_clr = 1'b0, int_mask = 1'b0;
    logic [7:0] rd_data, unused;
    logic [1:0] just;
    logic       evt, irq;

    int         n_chk = 0, n_fail = 0;
    int         model_unused = DEPTH;
    logic [7:0] exp_q[$];
    logic [7:0] seq = 8'h10;
    logic       rd_seen = 1'b0;

    always #(CLK_P/2) clk = ~clk;

    jes_elastic_store i_jes_elastic_store (
        .clk(clk), .rst_n(rst_n), .mode_i(mode), .loop_sel_i(loop_sel),
        .wr_en_i(wr_en), .wr_data_i(wr_data), .rd_en_i(rd_en),
        .rd_data_o(rd_data), .unused_o(unused), .opp_i(opp),
        .thr_ld_i(thr_ld), .thr_hi_i(thr_hi), .thr_lo_i(thr_lo),
        .just_o(just), .evt_clr_i(evt_clr), .int_mask_i(int_mask),
        .evt_o(evt), .irq_o(irq)
    );

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Monitor: note a read at the edge, compare on the following negedge.
    always @(posedge clk) rd_seen <= rd_en;
    always @(negedge clk) begin
        if (rd_seen) begin
            logic [7:0] e;
            e = (exp_q.size() > 0) ? exp_q.pop_front() : 8'h00;
            check("R2/R4 read data", rd_data, e);
        end
    end

    task automatic wr_word();
        wr_en = 1'b1; wr_data = seq;
        if (model_unused > 0) begin exp_q.push_back(seq); model_unused--; end
        seq++;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wr_n(int n);
        for (int i = 0; i < n; i++) wr_word();
    endtask

    task automatic rd_word();
        rd_en = 1'b1;
        if (model_unused < DEPTH) model_unused++;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic pulse_opp(string req, int exp);
        opp = 1'b1;
        @(negedge clk);
        opp = 1'b0;
        check(req, just, exp);
    endtask

    task automatic set_mode(logic [1:0] m, string req);
        mode = m;
        @(negedge clk);
        exp_q.delete(); model_unused = DEPTH / 2;
        check({req, " recentre unused"}, unused, 64);
        check({req, " recentre just"}, just, 0);
    endtask

    initial begin
        #(CLK_P * 150000);
        n_fail++; n_chk++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check("R1 unused", unused, 128);
        check("R1 just", just, 0);
        check("R1 rd_data", rd_data, 0);
        check("R1 evt", evt, 0);
        check("R1 irq", irq, 0);

        // R2 order and count; R4 empty read
        wr_n(5);
        check("R2 unused after writes", unused, 123);
        for (int i = 0; i < 5; i++) rd_word();
        check("R2 unused after reads", unused, 128);
        rd_word();
        @(negedge clk);
        check("R4 unused after empty read", unused, 128);

        // R5 positive at default thresholds, R7 hold
        pulse_opp("R5 positive unused 128", 1);
        wr_word();
        @(negedge clk);
        check("R7 decision held", just, 1);
        rd_word();

        // R1 default thresholds, R6/R7 around 40/39
        wr_n(88);
        check("R2 unused 40", unused, 40);
        pulse_opp("R7 none at 40", 0);
        wr_word();
        pulse_opp("R7 none at 39", 0);
        wr_word();
        pulse_opp("R6 negative at 38", 2);

        // R9 loopback thresholds 5/4
        thr_hi = 7'd5; thr_lo = 7'd4; thr_ld = 1'b1;
        @(negedge clk);
        thr_ld = 1'b0;
        wr_n(32);
        pulse_opp("R9 positive at 6", 1);
        wr_word();
        pulse_opp("R9 none at 5", 0);
        wr_word();
        pulse_opp("R9 none at 4", 0);
        wr_word();
        pulse_opp("R9 negative at 3", 2);

        // R3 overflow, R11 mask, R10 clear and collision
        wr_n(3);
        check("R3 full", unused, 0);
        wr_word();
        check("R3 unused stays 0", unused, 0);
        check("R3 event set", evt, 1);
        check("R11 irq unmasked", irq, 1);
        int_mask = 1'b1;
        @(negedge clk);
        check("R11 irq masked", irq, 0);
        check("R10 event sticky", evt, 1);
        int_mask = 1'b0;
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        check("R10 event cleared", evt, 0);
        evt_clr = 1'b1;
        wr_word();
        evt_clr = 1'b0;
        check("R10 overflow beats clear", evt, 1);
        evt_clr = 1'b1;
        @(negedge clk);
        evt_clr = 1'b0;
        check("R10 cleared again", evt, 0);

        // R3 drain: dropped words must not appear
        for (int i = 0; i < DEPTH; i++) rd_word();
        rd_word();
        @(negedge clk);
        check("R3 drained", unused, 128);

        // R8 synchronous modes, R12 recentre
        pulse_opp("R9 positive at 128", 1);
        set_mode(2'b01, "R12 bit-sync");
        pulse_opp("R8 bit-sync none", 0);
        set_mode(2'b10, "R12 byte-sync");
        pulse_opp("R8 byte-sync none", 0);
        set_mode(2'b11, "R12 spare");
        pulse_opp("R8 spare none", 0);
        set_mode(2'b00, "R12 async");
        pulse_opp("R5 positive at 64", 1);
        wr_n(3);
        check("R12 unused before loopback", unused, 61);
        loop_sel = 1'b1;
        @(negedge clk);
        check("R12 loopback recentre unused", unused, 64);
        check("R12 loopback recentre just", just, 0);
        wr_word();
        check("R12 no recentre while held", unused, 63);

        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule